// File: doc/BRIEF.md
# Set-Associative TLB Command Engine

This block holds the main translation buffer of a memory management unit and lets software maintain it through four registers: a first page descriptor (virtual page number, address-space identifier, present bit), a second page descriptor (frame number and six permission bits), an index register and a command register. Software loads the descriptors, optionally sets the index, then writes a command code. The engine carries the command out in one busy cycle and returns to idle.

Six commands exist. A probe searches the set selected by the first descriptor and either loads the matching linear index or raises an error flag. A distinct code marks the case where two ways match. Get-index chooses a slot for a later write. Write and write-without-flush commit both descriptors to the indexed entry; only the first of them pulses the invalidate output toward the attached micro-TLBs. Read copies an entry back into the descriptors. A flush-only command pulses the invalidate output and touches nothing else. A typical refill is probe, then get-index on a miss, then write; an eviction during refill uses write-without-flush so that the micro-TLBs keep their contents.

The controller has seven states. ST_IDLE accepts register writes. A command write moves it to ST_READ, ST_WRITE, ST_WRITE_NI, ST_PROBE, ST_GETIDX or ST_FLUSH according to the code. Each of these states lasts one cycle and then returns unconditionally to ST_IDLE.

Top module: `tlb_cmd_engine`

## Requirements
- R1: After reset the descriptor and index registers read zero, every entry reads back as zero, and busy and utlb_inv are low.
- R2: Register addresses are 0 first descriptor, 1 second descriptor, 2 index, 3 command (reads as zero). A command write makes busy high for exactly the next cycle. Register writes made while busy is high are ignored.
- R3: The first descriptor holds the address-space identifier in bits 7:0, the present bit in bit 8 and the virtual page number from bit 9 up. The set is the low log2(SETS) bits of the page number. The linear index of an entry is set × WAYS + way.
- R4: Command code 4 (probe) with exactly one way whose present bit is set and whose page number and identifier both equal the first descriptor's loads that way's linear index into the index register and clears both flags.
- R5: A probe with no matching way sets index bit 31 (lookup error), clears bit 30 and keeps the index field.
- R6: A probe that matches two or more ways sets both bit 31 and bit 30 and keeps the index field. Writing duplicate entries raises no error.
- R7: Command code 5 (get-index) loads the lowest way of the selected set whose present bit is clear. If every way is present, it loads the way named by the set's round-robin pointer, which starts at way 0 and advances by one after each such choice. The flags are cleared.
- R8: Command code 2 (write) stores both descriptors at the index field and drives utlb_inv high for exactly one cycle.
- R9: Command code 3 (write without flush) stores the entry as a write does, but utlb_inv stays low.
- R10: Command code 1 (read) copies the entry at the index field into both descriptors.
- R11: Command code 6 pulses utlb_inv for one cycle and leaves every entry and the whole index register unchanged, including when the error flags are set.
- R12: An entry whose present bit is clear never matches a probe, so writing zeros erases it.
- R13: Command codes 0 and 7 do nothing: busy stays low, there is no pulse and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| busy | output | 1 | High during the cycle a command executes |
| utlb_inv | output | 1 | One-cycle micro-TLB invalidate pulse |

## Verification
A command written at one clock edge sets busy and any invalidate pulse in the following cycle. Its register and storage results appear at the next edge. The bench drives on falling edges, samples busy and utlb_inv in the busy cycle, checks that the pulse has ended one cycle later, and reads registers only after the second edge. Reads are combinational, so each readback is sampled shortly after the address settles, away from any edge. A small 4-set, 2-way configuration lets the bench sweep every entry, every set and both identifiers against a model computed from the requirements.

// File: rtl/tlb_cmd_pkg.sv
package tlb_cmd_pkg;

    localparam logic [1:0] ADDR_PD0 = 2'd0;
    localparam logic [1:0] ADDR_PD1 = 2'd1;
    localparam logic [1:0] ADDR_IDX = 2'd2;
    localparam logic [1:0] ADDR_CMD = 2'd3;

    localparam int ASID_W    = 8;
    localparam int VALID_BIT = 8;
    localparam int VPN_LSB   = 9;
    localparam int PERM_W    = 6;
    localparam int MISS_BIT  = 31;
    localparam int DUP_BIT   = 30;

    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_READ     = 3'd1,
        CMD_WRITE    = 3'd2,
        CMD_WRITE_NI = 3'd3,
        CMD_PROBE    = 3'd4,
        CMD_GETIDX   = 3'd5,
        CMD_IVUTLB   = 3'd6,
        CMD_RSVD     = 3'd7
    } tlb_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_WRITE_NI,
        ST_PROBE,
        ST_GETIDX,
        ST_FLUSH
    } tlb_state_e;

endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
    parameter int SETS  = 128,
    parameter int WAYS  = 4,
    parameter int PD0_W = 28,
    parameter int PD1_W = 26
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [$clog2(SETS*WAYS)-1:0]      entry_idx,
    input  logic [PD0_W-1:0]                  wr_pd0,
    input  logic [PD1_W-1:0]                  wr_pd1,
    output logic [PD0_W-1:0]                  rd_pd0,
    output logic [PD1_W-1:0]                  rd_pd1,
    input  logic [$clog2(SETS)-1:0]           set_sel,
    output logic [WAYS-1:0][PD0_W-1:0]        set_pd0
);
    localparam int ENTRIES = SETS * WAYS;

    logic [PD0_W-1:0] mem_pd0 [ENTRIES];
    logic [PD1_W-1:0] mem_pd1 [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                mem_pd0[e] <= '0;
                mem_pd1[e] <= '0;
            end
        end else if (we) begin
            mem_pd0[entry_idx] <= wr_pd0;
            mem_pd1[entry_idx] <= wr_pd1;
        end
    end

    assign rd_pd0 = mem_pd0[entry_idx];
    assign rd_pd1 = mem_pd1[entry_idx];

    for (genvar w = 0; w < WAYS; w++) begin : g_set_rd
        assign set_pd0[w] = mem_pd0[int'(set_sel) * WAYS + w];
    end

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int WAYS  = 4,
    parameter int VPN_W = 19,
    parameter int PD0_W = 28
) (
    input  logic [WAYS-1:0][PD0_W-1:0]  set_pd0,
    input  logic [VPN_W-1:0]            key_vpn,
    input  logic [7:0]                  key_asid,
    output logic                        hit_any,
    output logic                        hit_dup,
    output logic [$clog2(WAYS)-1:0]     hit_way,
    output logic [WAYS-1:0]             present
);
    import tlb_cmd_pkg::*;

    logic [WAYS-1:0] hit_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign present[w] = set_pd0[w][VALID_BIT];
        assign hit_vec[w] = present[w]
                          && (set_pd0[w][PD0_W-1:VPN_LSB] == key_vpn)
                          && (set_pd0[w][ASID_W-1:0] == key_asid);
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = w[$clog2(WAYS)-1:0];
        end
    end

    assign hit_any = |hit_vec;
    assign hit_dup = ($countones(hit_vec) > 1);

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int SETS = 128,
    parameter int WAYS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(SETS)-1:0]     set_sel,
    input  logic [WAYS-1:0]             present,
    input  logic                        advance,
    output logic [$clog2(WAYS)-1:0]     victim_way
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] rr_ptr [SETS];
    logic [WAY_W-1:0] free_way;
    logic             all_full;

    always_comb begin
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!present[w]) free_way = w[WAY_W-1:0];
        end
    end

    assign all_full   = &present;
    assign victim_way = all_full ? rr_ptr[set_sel] : free_way;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_ptr[s] <= '0;
        end else if (advance && all_full) begin
            rr_ptr[set_sel] <= rr_ptr[set_sel] + 1'b1;
        end
    end

    // R7: a victim choice on a full set moves that set's pointer on by one
    assert_rr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && all_full) |=> (rr_ptr[$past(set_sel)] == $past(rr_ptr[set_sel]) + 1'b1));

endmodule

// File: rtl/tlb_cmd_engine.sv
module tlb_cmd_engine #(
    parameter int SETS  = 128,
    parameter int WAYS  = 4,
    parameter int VPN_W = 19,
    parameter int PFN_W = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        busy,
    output logic        utlb_inv
);
    import tlb_cmd_pkg::*;

    localparam int ENTRIES = SETS * WAYS;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int SET_W   = $clog2(SETS);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int PD0_W   = VPN_LSB + VPN_W;
    localparam int PD1_W   = PFN_W + PERM_W;

    tlb_state_e         state_q, state_d;
    logic [PD0_W-1:0]   pd0_q;
    logic [PD1_W-1:0]   pd1_q;
    logic [IDX_W-1:0]   idx_q;
    logic               miss_q, dup_q;

    logic [SET_W-1:0]           key_set;
    logic [WAYS-1:0][PD0_W-1:0] set_pd0;
    logic [PD0_W-1:0]           rd_pd0;
    logic [PD1_W-1:0]           rd_pd1;
    logic                       hit_any, hit_dup;
    logic [WAY_W-1:0]           hit_way, victim_way;
    logic [WAYS-1:0]            present;
    logic                       store_we, cmd_wr, sw_wr;

    assign key_set = pd0_q[VPN_LSB +: SET_W];

    function automatic logic [IDX_W-1:0] lin_idx(input logic [SET_W-1:0] s,
                                                 input logic [WAY_W-1:0] w);
        return IDX_W'(s) * IDX_W'(WAYS) + IDX_W'(w);
    endfunction

    tlb_store #(.SETS(SETS), .WAYS(WAYS), .PD0_W(PD0_W), .PD1_W(PD1_W)) store_i (
        .clk(clk), .rst_n(rst_n), .we(store_we), .entry_idx(idx_q),
        .wr_pd0(pd0_q), .wr_pd1(pd1_q), .rd_pd0(rd_pd0), .rd_pd1(rd_pd1),
        .set_sel(key_set), .set_pd0(set_pd0)
    );

    tlb_match #(.WAYS(WAYS), .VPN_W(VPN_W), .PD0_W(PD0_W)) match_i (
        .set_pd0(set_pd0), .key_vpn(pd0_q[PD0_W-1:VPN_LSB]),
        .key_asid(pd0_q[ASID_W-1:0]), .hit_any(hit_any), .hit_dup(hit_dup),
        .hit_way(hit_way), .present(present)
    );

    tlb_victim #(.SETS(SETS), .WAYS(WAYS)) victim_i (
        .clk(clk), .rst_n(rst_n), .set_sel(key_set), .present(present),
        .advance(state_q == ST_GETIDX), .victim_way(victim_way)
    );

    assign cmd_wr = reg_wr && (state_q == ST_IDLE) && (reg_addr == ADDR_CMD);
    assign sw_wr  = reg_wr && (state_q == ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = ST_IDLE;
        if (cmd_wr) begin
            unique case (tlb_cmd_e'(reg_wdata[2:0]))
                CMD_READ:     state_d = ST_READ;
                CMD_WRITE:    state_d = ST_WRITE;
                CMD_WRITE_NI: state_d = ST_WRITE_NI;
                CMD_PROBE:    state_d = ST_PROBE;
                CMD_GETIDX:   state_d = ST_GETIDX;
                CMD_IVUTLB:   state_d = ST_FLUSH;
                CMD_NONE,
                CMD_RSVD:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from the state
    always_comb begin
        busy     = 1'b0;
        utlb_inv = 1'b0;
        store_we = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_READ:     busy = 1'b1;
            ST_WRITE:    begin busy = 1'b1; store_we = 1'b1; utlb_inv = 1'b1; end
            ST_WRITE_NI: begin busy = 1'b1; store_we = 1'b1; end
            ST_PROBE:    busy = 1'b1;
            ST_GETIDX:   busy = 1'b1;
            ST_FLUSH:    begin busy = 1'b1; utlb_inv = 1'b1; end
        endcase
    end

    // software-visible registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd0_q  <= '0;
            pd1_q  <= '0;
            idx_q  <= '0;
            miss_q <= 1'b0;
            dup_q  <= 1'b0;
        end else begin
            if (sw_wr) begin
                if (reg_addr == ADDR_PD0) pd0_q <= reg_wdata[PD0_W-1:0];
                if (reg_addr == ADDR_PD1) pd1_q <= reg_wdata[PD1_W-1:0];
                if (reg_addr == ADDR_IDX) begin
                    idx_q  <= reg_wdata[IDX_W-1:0];
                    miss_q <= reg_wdata[MISS_BIT];
                    dup_q  <= reg_wdata[DUP_BIT];
                end
            end
            if (state_q == ST_READ) begin
                pd0_q <= rd_pd0;
                pd1_q <= rd_pd1;
            end
            if (state_q == ST_PROBE) begin
                if (hit_any && !hit_dup) begin
                    idx_q  <= lin_idx(key_set, hit_way);
                    miss_q <= 1'b0;
                    dup_q  <= 1'b0;
                end else begin
                    miss_q <= 1'b1;
                    dup_q  <= hit_dup;
                end
            end
            if (state_q == ST_GETIDX) begin
                idx_q  <= lin_idx(key_set, victim_way);
                miss_q <= 1'b0;
                dup_q  <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_PD0: reg_rdata[PD0_W-1:0] = pd0_q;
            ADDR_PD1: reg_rdata[PD1_W-1:0] = pd1_q;
            ADDR_IDX: begin
                reg_rdata[IDX_W-1:0] = idx_q;
                reg_rdata[MISS_BIT]  = miss_q;
                reg_rdata[DUP_BIT]   = dup_q;
            end
            ADDR_CMD: reg_rdata = '0;
        endcase
    end

    // R8 / R11: the invalidate pulse never lasts more than one cycle
    assert_inv_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        utlb_inv |=> !utlb_inv);

    // R2: a command keeps the engine busy for one cycle only
    assert_busy_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R6: the duplicate code is always accompanied by the lookup error
    assert_dup_has_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROBE) |=> (!dup_q || miss_q));

    // R7: get-index leaves both flags clear
    assert_getidx_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GETIDX) |=> (!miss_q && !dup_q));

    // R11: the flush-only command leaves the index register untouched
    assert_flush_keeps_index_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> ($stable(idx_q) && $stable(miss_q) && $stable(dup_q)));

endmodule

// File: tb/tlb_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module tlb_cmd_engine_tb_top;

    localparam int SETS = 4;
    localparam int WAYS = 2;
    localparam int VPN_W = 6;
    localparam int PFN_W = 4;
    localparam int ENT = SETS * WAYS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy, utlb_inv;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model
    logic [31:0] m_pd0 [ENT];
    logic [31:0] m_pd1 [ENT];
    int          m_rr [SETS];
    logic [31:0] r_pd0, r_pd1;
    int          r_idx;
    bit          r_miss, r_dup;
    bit          inv_seen, busy_seen;

    tlb_cmd_engine #(.SETS(SETS), .WAYS(WAYS), .VPN_W(VPN_W), .PFN_W(PFN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .utlb_inv(utlb_inv)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] mk_pd0(int vpn, int v, int asid);
        return (32'(vpn) << 9) | (32'(v) << 8) | 32'(asid);
    endfunction

    function automatic logic [31:0] idx_word();
        return (32'(r_miss) << 31) | (32'(r_dup) << 30) | 32'(r_idx);
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 2'd0) r_pd0 = d & 32'h7FFF;
        if (a == 2'd1) r_pd1 = d & 32'h3FF;
        if (a == 2'd2) begin
            r_idx = int'(d[2:0]); r_miss = d[31]; r_dup = d[30];
        end
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic model_cmd(int c);
        int s, n, hw, fw;
        s = int'(r_pd0[10:9]);
        case (c)
            1: begin r_pd0 = m_pd0[r_idx]; r_pd1 = m_pd1[r_idx]; end
            2, 3: begin m_pd0[r_idx] = r_pd0; m_pd1[r_idx] = r_pd1; end
            4: begin
                n = 0; hw = 0;
                for (int w = WAYS - 1; w >= 0; w--) begin
                    if (m_pd0[s*WAYS+w][8] && m_pd0[s*WAYS+w][14:9] == r_pd0[14:9]
                        && m_pd0[s*WAYS+w][7:0] == r_pd0[7:0]) begin
                        n++; hw = w;
                    end
                end
                if (n == 1) begin r_idx = s*WAYS + hw; r_miss = 0; r_dup = 0; end
                else begin r_miss = 1; r_dup = (n > 1); end
            end
            5: begin
                fw = -1;
                for (int w = WAYS - 1; w >= 0; w--) if (!m_pd0[s*WAYS+w][8]) fw = w;
                if (fw < 0) begin fw = m_rr[s]; m_rr[s] = (m_rr[s] + 1) % WAYS; end
                r_idx = s*WAYS + fw; r_miss = 0; r_dup = 0;
            end
            default: ;
        endcase
    endtask

    // issue a command; busy cycle sampled, results read after second edge
    task automatic cmd(int c);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'(c);
        @(negedge clk);
        reg_wr = 1'b0;
        inv_seen = utlb_inv; busy_seen = busy;
        @(negedge clk);
        check("R8 pulse ends", {31'b0, utlb_inv}, 32'd0);
        model_cmd(c);
    endtask

    task automatic chk_regs(string req);
        logic [31:0] v;
        rd(2'd0, v); check(req, v, r_pd0);
        rd(2'd1, v); check(req, v, r_pd1);
        rd(2'd2, v); check(req, v, idx_word());
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < ENT; i++) begin m_pd0[i] = 0; m_pd1[i] = 0; end
        for (int s = 0; s < SETS; s++) m_rr[s] = 0;
        r_pd0 = 0; r_pd1 = 0; r_idx = 0; r_miss = 0; r_dup = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_regs("R1 reset regs");
        check("R1 reset busy", {30'b0, busy, utlb_inv}, 32'd0);
        for (int i = 0; i < ENT; i++) begin
            wr(2'd2, 32'(i));
            cmd(1);
            check("R10 read no pulse", {31'b0, inv_seen}, 32'd0);
            chk_regs("R1 entry zero");
        end

        // fill all entries through get-index and write
        for (int vpn = 0; vpn < ENT; vpn++) begin
            wr(2'd0, mk_pd0(vpn, 1, 5));
            cmd(5);
            check("R2 busy one cycle", {31'b0, busy_seen}, 32'd1);
            rd(2'd2, v);
            check("R3 linear index", v, 32'((vpn % SETS) * WAYS + vpn / SETS));
            check("R7 free way", v, idx_word());
            wr(2'd1, 32'(vpn * 37 + 3) & 32'h3FF);
            cmd(2);
            check("R8 write pulse", {31'b0, inv_seen}, 32'd1);
        end

        // probe sweep over pages and identifiers
        for (int vpn = 0; vpn < 16; vpn++) begin
            for (int a = 5; a <= 6; a++) begin
                wr(2'd0, mk_pd0(vpn, 1, a));
                cmd(4);
                rd(2'd2, v);
                if (vpn < ENT && a == 5)
                    check("R4 probe hit", v, 32'((vpn % SETS) * WAYS + vpn / SETS));
                else
                    check("R5 probe miss", v[31:30], 2'b10);
                check("R4 R5 model", v, idx_word());
            end
        end

        // read sweep
        for (int i = 0; i < ENT; i++) begin
            wr(2'd2, 32'(i));
            cmd(1);
            chk_regs("R10 read back");
        end

        // round-robin on a full set 0
        wr(2'd0, mk_pd0(8, 1, 5));
        for (int k = 0; k < 3; k++) begin
            cmd(5);
            rd(2'd2, v);
            check("R7 round robin", v, 32'(k % 2));
        end
        wr(2'd1, 32'h2AA);
        cmd(3);
        check("R9 no pulse", {31'b0, inv_seen}, 32'd0);
        cmd(4);
        rd(2'd2, v); check("R9 stored", v, 32'd0);
        wr(2'd0, mk_pd0(0, 1, 5));
        cmd(4);
        rd(2'd2, v); check("R9 overwritten miss", v[31:30], 2'b10);

        // duplicate: page 8 placed in way 1 as well
        wr(2'd0, mk_pd0(8, 1, 5));
        wr(2'd2, 32'd1);
        cmd(2);
        rd(2'd2, v); check("R6 write no error", v, 32'd1);
        cmd(4);
        rd(2'd2, v); check("R6 duplicate code", v, 32'hC000_0001);

        // erase with zeros
        wr(2'd0, 0); wr(2'd1, 0); wr(2'd2, 32'd1);
        cmd(2);
        wr(2'd0, mk_pd0(8, 1, 5));
        cmd(4);
        rd(2'd2, v); check("R12 dup removed", v, 32'd0);
        wr(2'd0, mk_pd0(1, 0, 5)); wr(2'd2, 32'd2);
        cmd(3);
        wr(2'd0, mk_pd0(1, 1, 5));
        cmd(4);
        rd(2'd2, v); check("R12 not present no match", v, 32'h8000_0002);

        // flush-only command with error flags set
        wr(2'd2, 32'hC000_0005);
        cmd(6);
        check("R11 pulse", {31'b0, inv_seen}, 32'd1);
        chk_regs("R11 regs kept");
        for (int i = 0; i < ENT; i++) begin
            wr(2'd2, 32'(i));
            cmd(1);
            chk_regs("R11 entries kept");
        end

        // unused codes
        wr(2'd0, mk_pd0(3, 1, 9));
        for (int c = 0; c < 8; c += 7) begin
            cmd(c);
            check("R13 no busy", {30'b0, busy_seen, inv_seen}, 32'd0);
            chk_regs("R13 regs kept");
        end

        // write while busy is ignored
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'd4;
        @(negedge clk);
        check("R2 busy", {31'b0, busy}, 32'd1);
        reg_addr = 2'd0; reg_wdata = 32'h0000_7FFF;
        @(negedge clk);
        reg_wr = 1'b0;
        model_cmd(4);
        chk_regs("R2 busy write ignored");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule